// File: doc/BRIEF.md
# I2C Data FIFOs with Watermark Interrupts

This block holds the transmit and receive byte queues of an I2C controller. Software reaches it through a small word-indexed register bus: it writes bytes to send into the transmit queue, reads received bytes out of the receive queue, and programs each queue's enable and trigger level. On the other side, the I2C byte engine pops transmit bytes and pushes received bytes through plain strobe ports. It also supplies an idle-period tick and a vector of transfer-event pulses.

The block raises one interrupt line. It is driven by a status word that mixes two live watermark conditions (transmit running low, receive filling up) with sticky flags. The sticky flags record a push into a full queue, a pop from an empty queue, a receive batch left idle too long, and transfer events. Sticky flags are cleared by writing ones to them, so software can write back the value it read and clear exactly what it saw. An interrupt-enable word masks which pending bits reach the line.

Register word indices: 0 queue control, 1 trailing count, 2 interrupt enable, 3 interrupt status, 4 queue status, 5 transmit data (write pushes), 6 receive data (read pops). Other indices read zero and ignore writes.

Top module: `i2c_fifo_irq`

## Requirements
- R1: After reset, both queues are disabled and empty. The queue status word reads 0x0100_0100, the interrupt status reads 0, and irq is low.
- R2: The control word holds the receive enable at bit 0, the transmit enable at bit 1, the receive trigger in bits 10:4 and the transmit trigger in bits 22:16, and it reads back as written. While a queue's enable is 0, the queue is held empty. While disabled, its pushes and pops are ignored, set no flags, and reads of it return 0.
- R3: Bytes written to index 5 leave at txByte in write order. Each cycle with txPop high advances to the next byte.
- R4: Bytes pushed with rxPush are returned in push order by reads of index 6. Each such read removes one byte.
- R5: The queue status word carries the transmit level in bits 6:0, transmit full at bit 7, transmit empty at bit 8, the receive level in bits 22:16, receive full at bit 23 and receive empty at bit 24.
- R6: Interrupt status bit 0 is high exactly while the transmit queue is enabled and its level is at or below the transmit trigger.
- R7: Interrupt status bit 1 is high exactly while the receive queue is enabled and its level is at or above the receive trigger.
- R8: A push into a full queue drops the byte and leaves the level at the depth. It sets bit 3 for the transmit queue and bit 5 for the receive queue.
- R9: A pop from an empty queue returns 0. It sets bit 2 for the transmit queue and bit 4 for the receive queue.
- R10: Let N be the trailing count at index 1. While the receive queue holds data and sees no push or read, the N+1-th idleTick pulse sets bit 6. Any receive push or read restarts the count.
- R11: A pulse on evtIn[k] sets interrupt status bit 7+k.
- R12: Writing index 3 clears the sticky bits (2 and up) written with 1 and leaves bits 0 and 1 unaffected. A flag that is set in the same cycle as it is cleared stays set.
- R13: irq is high exactly while some interrupt status bit and the matching bit of the enable word at index 2 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrite | input | 1 | Register write strobe |
| regRead | input | 1 | Register read strobe (pops the receive queue at index 6) |
| regAddr | input | 4 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| txPop | input | 1 | Engine takes the transmit head byte |
| txByte | output | 8 | Transmit head byte, 0 when empty |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| idleTick | input | 1 | One idle period of the bus has elapsed |
| evtIn | input | EVT_N | Transfer-event pulses |
| irq | output | 1 | Interrupt request |

## Verification
The trailing flag is the hardest condition to reach. It needs the receive queue to hold data while a chosen number of idle ticks pass with no receive traffic, and register reads of other indices must not disturb the count. The bench programs a count of 3 and confirms that empty-queue ticks do nothing. It then pushes one byte and shows the flag still clear after three ticks and set after the fourth. The set-versus-clear race is reached by driving an event pulse in the same cycle as a clearing write to the status word.

// File: rtl/i2cfifo_pkg.sv
package i2cfifo_pkg;
  localparam int LVL_FIELD = 7;

  localparam int IS_TXAE  = 0;
  localparam int IS_RXAF  = 1;
  localparam int IS_TXUR  = 2;
  localparam int IS_TXOR  = 3;
  localparam int IS_RXUR  = 4;
  localparam int IS_RXOR  = 5;
  localparam int IS_TRAIL = 6;
  localparam int IS_EVT0  = 7;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_TRAIL = 4'd1;
  localparam logic [3:0] A_IEN   = 4'd2;
  localparam logic [3:0] A_ISTAT = 4'd3;
  localparam logic [3:0] A_FSTAT = 4'd4;
  localparam logic [3:0] A_TXD   = 4'd5;
  localparam logic [3:0] A_RXD   = 4'd6;

  typedef struct packed {
    logic       txPush;
    logic       txPop;
    logic       rxPush;
    logic       rxPop;
    logic       txFlush;
    logic       rxFlush;
    logic [7:0] txData;
    logic [7:0] rxData;
  } fifoStrobes_t;
endpackage

// File: rtl/i2c_byte_fifo.sv
module i2c_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == LVL_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push & ~full & ~flush;
  assign doPop  = pop & ~empty & ~flush;
  assign level  = count;
  assign rdata  = empty ? 8'h00 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      count <= count + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end
endmodule

// File: rtl/i2c_fifo_dp.sv
module i2c_fifo_dp
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  output logic [7:0]       txHead,
  output logic [7:0]       rxHead,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel,
  output logic             txFull,
  output logic             txEmpty,
  output logic             rxFull,
  output logic             rxEmpty
);
  i2c_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_txq (
    .clk(clk), .rstN(rstN), .flush(strobes.txFlush),
    .push(strobes.txPush), .pop(strobes.txPop), .wdata(strobes.txData),
    .rdata(txHead), .level(txLevel), .full(txFull), .empty(txEmpty)
  );

  i2c_byte_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_rxq (
    .clk(clk), .rstN(rstN), .flush(strobes.rxFlush),
    .push(strobes.rxPush), .pop(strobes.rxPop), .wdata(strobes.rxData),
    .rdata(rxHead), .level(rxLevel), .full(rxFull), .empty(rxEmpty)
  );
endmodule

// File: rtl/i2c_fifo_ctrl.sv
module i2c_fifo_ctrl
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int LVL_W   = $clog2(DEPTH + 1),
  parameter int EVT_N   = 5,
  parameter int TRAIL_W = 4,
  parameter int INT_W   = IS_EVT0 + EVT_N
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic             regRead,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             txPop,
  input  logic             rxPush,
  input  logic [7:0]       rxByte,
  input  logic             idleTick,
  input  logic [EVT_N-1:0] evtIn,
  input  logic [7:0]       rxHead,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic             txFull,
  input  logic             txEmpty,
  input  logic             rxFull,
  input  logic             rxEmpty,
  output fifoStrobes_t     strobes,
  output logic [INT_W-1:0] intStatus,
  output logic             irq
);
  localparam logic [INT_W-1:0] STICKY_MASK = {{(INT_W-2){1'b1}}, 2'b00};

  logic                 rxEn, txEn;
  logic [LVL_FIELD-1:0] rxTrig, txTrig, txLvl7, rxLvl7;
  logic [TRAIL_W-1:0]   trailCnt, trailTimer, trailNext;
  logic [INT_W-1:0]     intEn, sticky, stickyNext, setMask, clrMask;
  logic                 wrCtrl, wrTrail, wrIen, wrStat;
  logic                 busTxPush, busRxPop, engTxPop, engRxPush;
  logic                 rxActive, trailArmed, trailHit;

  assign wrCtrl  = regWrite && regAddr == A_CTRL;
  assign wrTrail = regWrite && regAddr == A_TRAIL;
  assign wrIen   = regWrite && regAddr == A_IEN;
  assign wrStat  = regWrite && regAddr == A_ISTAT;

  assign busTxPush = regWrite && regAddr == A_TXD && txEn;
  assign busRxPop  = regRead && regAddr == A_RXD && rxEn;
  assign engTxPop  = txPop & txEn;
  assign engRxPush = rxPush & rxEn;

  assign strobes.txPush  = busTxPush & ~txFull;
  assign strobes.txPop   = engTxPop & ~txEmpty;
  assign strobes.rxPush  = engRxPush & ~rxFull;
  assign strobes.rxPop   = busRxPop & ~rxEmpty;
  assign strobes.txFlush = ~txEn;
  assign strobes.rxFlush = ~rxEn;
  assign strobes.txData  = regWdata[7:0];
  assign strobes.rxData  = rxByte;

  assign txLvl7 = LVL_FIELD'(txLevel);
  assign rxLvl7 = LVL_FIELD'(rxLevel);

  // Trailing-data idle counter
  assign rxActive   = engRxPush | busRxPop;
  assign trailArmed = idleTick & rxEn & ~rxEmpty & ~rxActive;
  assign trailHit   = trailArmed && (trailTimer == trailCnt);

  always_comb begin
    if (!rxEn || rxEmpty || rxActive) trailNext = '0;
    else if (trailArmed && !trailHit) trailNext = trailTimer + 1'b1;
    else                              trailNext = trailTimer;
  end

  // Sticky flag update: sets win over clears
  always_comb begin
    setMask = '0;
    setMask[IS_TXUR]  = engTxPop & txEmpty;
    setMask[IS_TXOR]  = busTxPush & txFull;
    setMask[IS_RXUR]  = busRxPop & rxEmpty;
    setMask[IS_RXOR]  = engRxPush & rxFull;
    setMask[IS_TRAIL] = trailHit;
    setMask[IS_EVT0 +: EVT_N] = evtIn;
    clrMask    = wrStat ? regWdata[INT_W-1:0] : '0;
    stickyNext = ((sticky & ~clrMask) | setMask) & STICKY_MASK;
  end

  always_comb begin
    intStatus = sticky;
    intStatus[IS_TXAE] = txEn && (txLvl7 <= txTrig);
    intStatus[IS_RXAF] = rxEn && (rxLvl7 >= rxTrig);
  end

  assign irq = |(intStatus & intEn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxEn       <= 1'b0;
      txEn       <= 1'b0;
      rxTrig     <= '0;
      txTrig     <= '0;
      trailCnt   <= '0;
      intEn      <= '0;
      sticky     <= '0;
      trailTimer <= '0;
    end else begin
      if (wrCtrl) begin
        rxEn   <= regWdata[0];
        txEn   <= regWdata[1];
        rxTrig <= regWdata[4 +: LVL_FIELD];
        txTrig <= regWdata[16 +: LVL_FIELD];
      end
      if (wrTrail) trailCnt <= regWdata[TRAIL_W-1:0];
      if (wrIen)   intEn    <= regWdata[INT_W-1:0];
      sticky     <= stickyNext;
      trailTimer <= trailNext;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL: begin
        regRdata[0]                = rxEn;
        regRdata[1]                = txEn;
        regRdata[4 +: LVL_FIELD]   = rxTrig;
        regRdata[16 +: LVL_FIELD]  = txTrig;
      end
      A_TRAIL: regRdata[TRAIL_W-1:0] = trailCnt;
      A_IEN:   regRdata[INT_W-1:0]   = intEn;
      A_ISTAT: regRdata[INT_W-1:0]   = intStatus;
      A_FSTAT: begin
        regRdata[6:0]   = txLvl7;
        regRdata[7]     = txFull;
        regRdata[8]     = txEmpty;
        regRdata[22:16] = rxLvl7;
        regRdata[23]    = rxFull;
        regRdata[24]    = rxEmpty;
      end
      A_RXD:   regRdata[7:0] = rxHead;
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int EVT_N   = 5,
  parameter int TRAIL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrite,
  input  logic             regRead,
  input  logic [3:0]       regAddr,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             txPop,
  output logic [7:0]       txByte,
  input  logic             rxPush,
  input  logic [7:0]       rxByte,
  input  logic             idleTick,
  input  logic [EVT_N-1:0] evtIn,
  output logic             irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int INT_W = IS_EVT0 + EVT_N;

  fifoStrobes_t     strobes;
  logic [7:0]       rxHead;
  logic [LVL_W-1:0] txLevel, rxLevel;
  logic             txFull, txEmpty, rxFull, rxEmpty;
  logic [INT_W-1:0] intStatus;
  logic             txOff, rxOff;

  assign txOff = strobes.txFlush;
  assign rxOff = strobes.rxFlush;

  i2c_fifo_ctrl #(
    .DEPTH(DEPTH), .LVL_W(LVL_W), .EVT_N(EVT_N), .TRAIL_W(TRAIL_W), .INT_W(INT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .rxPush(rxPush), .rxByte(rxByte), .idleTick(idleTick),
    .evtIn(evtIn), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .strobes(strobes), .intStatus(intStatus), .irq(irq)
  );

  i2c_fifo_dp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .txHead(txByte), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty)
  );
endmodule

// File: rtl/i2c_fifo_irq_chk.sv
module i2c_fifo_irq_chk
  import i2cfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5,
  parameter int INT_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrite,
  input logic [3:0]       regAddr,
  input logic [31:0]      regWdata,
  input logic             txPop,
  input logic             rxPush,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             txFull,
  input logic             txEmpty,
  input logic             rxFull,
  input logic             rxEmpty,
  input logic             txOff,
  input logic             rxOff,
  input logic [INT_W-1:0] intStatus
);
  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= LVL_W'(DEPTH)) && (rxLevel <= LVL_W'(DEPTH)));

  // R5
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(txFull && txEmpty) && !(rxFull && rxEmpty));

  // R8
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == A_TXD && !txOff && txFull) |=> intStatus[IS_TXOR]);

  // R8
  rx_overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !rxOff && rxFull) |=> intStatus[IS_RXOR] && rxFull);

  // R9
  tx_underrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && !txOff && txEmpty) |=> intStatus[IS_TXUR]);

  // R2
  rx_held_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxOff |=> rxLevel == '0);

  // R12
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrite && regAddr == A_ISTAT && regWdata[IS_TXOR]) |=> !intStatus[IS_TXOR]);

  // R3
  tx_level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (txLevel == $past(txLevel)) || (txLevel == $past(txLevel) + 1'b1) ||
             (txLevel + 1'b1 == $past(txLevel)) || (txLevel == '0));
endmodule

bind i2c_fifo_irq i2c_fifo_irq_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W), .INT_W(INT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
  .txPop(txPop), .rxPush(rxPush), .txLevel(txLevel), .rxLevel(rxLevel),
  .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
  .txOff(txOff), .rxOff(rxOff), .intStatus(intStatus)
);

// File: tb/i2c_fifo_irq_tb.sv
module i2c_fifo_irq_tb;
  localparam int DEPTH = 16;
  localparam int EVT_N = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrite = 1'b0, regRead = 1'b0;
  logic [3:0]       regAddr = '0;
  logic [31:0]      regWdata = '0;
  logic [31:0]      regRdata;
  logic             txPop = 1'b0, rxPush = 1'b0, idleTick = 1'b0;
  logic [7:0]       txByte, rxByte = '0;
  logic [EVT_N-1:0] evtIn = '0;
  logic             irq;

  int nRun = 0, nFail = 0;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];

  always #4 clk = ~clk;

  i2c_fifo_irq #(.DEPTH(DEPTH), .EVT_N(EVT_N)) u_dut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regRead(regRead),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .txPop(txPop), .txByte(txByte), .rxPush(rxPush), .rxByte(rxByte),
    .idleTick(idleTick), .evtIn(evtIn), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares bytes as they leave either queue
  always begin
    logic [7:0] exp;
    @(negedge clk);
    #2;
    if (txPop) begin
      exp = (txQ.size() > 0) ? txQ.pop_front() : 8'h00;
      check("R3 tx byte order", {24'h0, txByte}, {24'h0, exp});
    end
    if (regRead && regAddr == 4'd6) begin
      exp = (rxQ.size() > 0) ? rxQ.pop_front() : 8'h00;
      check("R4 rx byte order", regRdata, {24'h0, exp});
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRead = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRead = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    check(req, v, exp);
  endtask

  task automatic txWrite(input logic [7:0] b, input bit accept);
    if (accept) txQ.push_back(b);
    busWrite(4'd5, {24'h0, b});
  endtask

  task automatic engPop();
    @(negedge clk); txPop = 1'b1;
    @(negedge clk); txPop = 1'b0;
  endtask

  task automatic engPush(input logic [7:0] b, input bit accept);
    if (accept) rxQ.push_back(b);
    @(negedge clk); rxPush = 1'b1; rxByte = b;
    @(negedge clk); rxPush = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); idleTick = 1'b1;
    @(negedge clk); idleTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    expectReg("R1 queue status at reset", 4'd4, 32'h0100_0100);
    expectReg("R1 int status at reset", 4'd3, 32'h0);
    check("R1 irq at reset", {31'h0, irq}, 32'h0);

    // R2 control layout: rx trig 4, tx trig 2, both enabled
    busWrite(4'd0, 32'h0002_0043);
    expectReg("R2 control readback", 4'd0, 32'h0002_0043);
    expectReg("R6 almost-empty at level 0", 4'd3, 32'h1);
    check("R13 masked irq low", {31'h0, irq}, 32'h0);
    busWrite(4'd2, 32'h1);
    @(negedge clk);
    check("R13 irq on enabled pending", {31'h0, irq}, 32'h1);

    // R3/R6 small batch
    txWrite(8'hA1, 1); txWrite(8'hA2, 1); txWrite(8'hA3, 1);
    expectReg("R6 almost-empty drops above trigger", 4'd3, 32'h0);
    check("R13 irq follows pending", {31'h0, irq}, 32'h0);
    expectReg("R5 tx level 3", 4'd4, 32'h0100_0003);
    for (int i = 0; i < 3; i++) engPop();

    // R8/R9 transmit limits
    for (int i = 0; i < DEPTH; i++) txWrite(8'(8'h10 + i), 1);
    expectReg("R5 tx full", 4'd4, 32'h0100_0090);
    txWrite(8'hEE, 0);
    expectReg("R8 tx overrun flag", 4'd3, 32'h8);
    expectReg("R8 tx level held at depth", 4'd4, 32'h0100_0090);
    for (int i = 0; i < DEPTH; i++) engPop();
    engPop();
    expectReg("R9 tx underrun flag", 4'd3, 32'hD);

    // R12 write-one-to-clear
    busWrite(4'd3, 32'h4);
    expectReg("R12 single bit cleared", 4'd3, 32'h9);
    busWrite(4'd3, 32'h9);
    expectReg("R12 write-back clears, live bit stays", 4'd3, 32'h1);
    busWrite(4'd2, 32'h8);
    @(negedge clk);
    check("R13 irq masked by enable", {31'h0, irq}, 32'h0);
    busWrite(4'd2, 32'h0);

    // R4/R7 receive
    engPush(8'h51, 1); engPush(8'h52, 1); engPush(8'h53, 1);
    expectReg("R7 below trigger", 4'd3, 32'h1);
    engPush(8'h54, 1);
    expectReg("R7 almost-full at trigger", 4'd3, 32'h3);
    expectReg("R5 rx level 4", 4'd4, 32'h0004_0100);
    for (int i = 0; i < 4; i++) busRead(4'd6, v);
    busRead(4'd6, v);
    expectReg("R9 rx underrun flag", 4'd3, 32'h11);
    busWrite(4'd3, 32'h10);

    for (int i = 0; i <= DEPTH; i++) engPush(8'(8'h60 + i), i < DEPTH);
    expectReg("R8 rx overrun flag", 4'd3, 32'h23);
    expectReg("R5 rx full", 4'd4, 32'h0090_0100);
    for (int i = 0; i < DEPTH; i++) busRead(4'd6, v);
    busWrite(4'd3, 32'h20);

    // R10 trailing
    busWrite(4'd1, 32'h3);
    for (int i = 0; i < 5; i++) tick();
    expectReg("R10 no trailing while empty", 4'd3, 32'h1);
    engPush(8'h77, 1);
    for (int i = 0; i < 3; i++) tick();
    expectReg("R10 not yet after N ticks", 4'd3, 32'h1);
    tick();
    expectReg("R10 trailing on tick N+1", 4'd3, 32'h41);
    busRead(4'd6, v);
    busWrite(4'd3, 32'h40);

    // R11 events and R13
    @(negedge clk); evtIn = 5'b00100;
    @(negedge clk); evtIn = '0;
    expectReg("R11 event bit 9", 4'd3, 32'h201);
    busWrite(4'd2, 32'h200);
    @(negedge clk);
    check("R13 irq from event", {31'h0, irq}, 32'h1);
    busWrite(4'd3, 32'h200);
    check("R13 irq drops after clear", {31'h0, irq}, 32'h0);
    @(negedge clk);
    regWrite = 1'b1; regAddr = 4'd3; regWdata = 32'h200; evtIn = 5'b00100;
    @(negedge clk);
    regWrite = 1'b0; evtIn = '0;
    expectReg("R12 set wins over clear", 4'd3, 32'h201);
    busWrite(4'd3, 32'h200);
    busWrite(4'd2, 32'h0);

    // R2 disabled queues
    busWrite(4'd0, 32'h0002_0042);
    engPush(8'h99, 0); engPush(8'h9A, 0);
    expectReg("R2 rx held empty", 4'd4, 32'h0100_0100);
    busRead(4'd6, v);
    expectReg("R2 no flags from disabled rx", 4'd3, 32'h1);
    txWrite(8'hC1, 0); txWrite(8'hC2, 0);
    busWrite(4'd0, 32'h0);
    expectReg("R2 tx flushed on disable", 4'd4, 32'h0100_0100);
    expectReg("R2 watermark off when disabled", 4'd3, 32'h0);

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule